// File: doc/BRIEF.md
# Calendar Real-Time Clock with Coherent Snapshot Reads

This block keeps wall-clock time and the calendar date in a set of cascaded counters: seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. A periodic tick enable, normally at 32.768 kHz or taken from an external rate trimmer, is divided down to a one-second step. Each step advances the counter chain with full carry handling, including month lengths and February in leap years. The cycle after each step, the block raises a one-cycle interrupt.

Software reaches the counters through a small address/data register port. Reading the seconds address returns the live seconds value. The same read also copies every counter into a bank of holding registers, so later reads of the other fields all come from one instant. The seconds count can still change between the copy and the later reads. Software therefore repeats seconds reads until two in a row agree, which takes two or three reads. Every read stalls the bus for exactly one wait state.

Setting the time is guarded. A field write takes effect only when the bus write just before it went to the enable address, and only when the value is in range for that field. Any bus write disarms the guard.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, with day of week 1, day of month 1, month 1 and year 0.
- R2: Seconds advance once per TICKS_PER_SEC asserted tick enables. The cycle after that step, `sec_irq` is high for exactly one cycle.
- R3: Seconds and minutes wrap from 59 to 0 and carry onward. Hours wrap from 23 to 0 and carry into the day counters.
- R4: Day of week steps on each day carry and wraps from 7 back to 1.
- R5: Day of month wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, and 31 for the other months except February. Month wraps from 12 to 1 and carries into year, which wraps from 99 to 0.
- R6: February has 29 days when the year is divisible by 4, and 28 days otherwise.
- R7: Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 enable. A read of address 0 returns the live seconds and copies all counters into the holding bank. A read of addresses 1 to 6 returns the holding bank and leaves it unchanged. Address 7 reads as 0. Read data are zero-extended binary.
- R8: A read holds `bus_wait` high in the first cycle of the access and low in the second cycle, when `bus_rdata` is valid. Writes complete in one cycle with no wait.
- R9: A field write is applied only if the previous bus write went to address 7, whatever value that write carried. Every bus write, including a rejected one, clears the arming. Reads leave the arming untouched.
- R10: A seconds read in the same cycle as a one-second step returns the value from before the step. A field write in the same cycle as a step overrides that field, while the other fields step normally.
- R11: An armed field write whose value is out of range is discarded. The ranges are: seconds and minutes 0–59, hours 0–23, day of week 1–7, day of month 1–31, month 1–12, year 0–99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timebase tick enable |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Field address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when the wait is released |
| bus_wait | output | 1 | Wait state for read accesses |
| sec_irq | output | 1 | One-cycle pulse after each seconds step |

## Verification
Two operations can fall in the same clock edge as the one-second step: a seconds read that triggers the snapshot, and an armed field write. The bench aligns the final prescaler tick with a seconds read in the same cycle and expects the value from before the step. It then aligns the final tick with an armed minutes write while seconds sit at 59. In that case the written minutes must replace the carry, seconds must wrap to 0 and hours must stay as they were.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HR   = 3'd2,
    F_DOW  = 3'd3,
    F_DOM  = 3'd4,
    F_MON  = 3'd5,
    F_YR   = 3'd6,
    F_WREN = 3'd7
  } rtc_field_e;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                      hr: 5'd0, mn: 6'd0, sec: 6'd0};

  // Last day of a month; two-digit year is leap when divisible by four
  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] d;
    case (mon)
      4'd2:                     d = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  d = 5'd30;
      default:                  d = 5'd31;
    endcase
    return d;
  endfunction

  function automatic logic field_ok(input rtc_field_e f, input logic [DATA_W-1:0] d);
    logic ok;
    case (f)
      F_SEC, F_MIN: ok = (d < 8'd60);
      F_HR:         ok = (d < 8'd24);
      F_DOW:        ok = (d >= 8'd1) && (d <= 8'd7);
      F_DOM:        ok = (d >= 8'd1) && (d <= 8'd31);
      F_MON:        ok = (d >= 8'd1) && (d <= 8'd12);
      F_YR:         ok = (d < 8'd100);
      default:      ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [DATA_W-1:0] field_value(input rtc_time_t t, input rtc_field_e f);
    logic [DATA_W-1:0] v;
    case (f)
      F_SEC:   v = {2'b00, t.sec};
      F_MIN:   v = {2'b00, t.mn};
      F_HR:    v = {3'b000, t.hr};
      F_DOW:   v = {5'b00000, t.dow};
      F_DOM:   v = {3'b000, t.dom};
      F_MON:   v = {4'b0000, t.mon};
      F_YR:    v = {1'b0, t.yr};
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic sec_stb,
  output logic sec_irq
);

  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             cnt_last;

  assign cnt_last = (cnt_q == CNT_LAST);
  assign sec_stb  = tick_en && cnt_last;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      cnt_d = cnt_last ? '0 : cnt_q + 1'b1;
    end
    irq_d = sec_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tick_en) begin
        cnt_q <= cnt_d;
      end
      irq_q <= irq_d;
    end
  end

  assign sec_irq = irq_q;

endmodule

// File: rtl/cal_rtc_chain.sv
module cal_rtc_chain
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_stb,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_field,
  input  logic [DATA_W-1:0] ld_data,
  output rtc_time_t         live_t
);

  rtc_time_t cur_q, nx;
  logic      c_sec, c_min, c_hr, c_dom, c_mon;
  logic      upd_en;

  assign c_sec  = (cur_q.sec >= 6'd59);
  assign c_min  = (cur_q.mn  >= 6'd59);
  assign c_hr   = (cur_q.hr  >= 5'd23);
  assign c_dom  = (cur_q.dom >= month_days(cur_q.mon, cur_q.yr));
  assign c_mon  = (cur_q.mon >= 4'd12);
  assign upd_en = sec_stb || ld_en;

  always_comb begin
    nx = cur_q;
    if (sec_stb) begin
      nx.sec = c_sec ? 6'd0 : cur_q.sec + 6'd1;
      if (c_sec) begin
        nx.mn = c_min ? 6'd0 : cur_q.mn + 6'd1;
        if (c_min) begin
          nx.hr = c_hr ? 5'd0 : cur_q.hr + 5'd1;
          if (c_hr) begin
            nx.dow = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
            nx.dom = c_dom ? 5'd1 : cur_q.dom + 5'd1;
            if (c_dom) begin
              nx.mon = c_mon ? 4'd1 : cur_q.mon + 4'd1;
              if (c_mon) begin
                nx.yr = (cur_q.yr >= 7'd99) ? 7'd0 : cur_q.yr + 7'd1;
              end
            end
          end
        end
      end
    end
    // A loaded field overrides whatever the step produced for it
    if (ld_en) begin
      case (rtc_field_e'(ld_field))
        F_SEC:   nx.sec = 6'(ld_data);
        F_MIN:   nx.mn  = 6'(ld_data);
        F_HR:    nx.hr  = 5'(ld_data);
        F_DOW:   nx.dow = 3'(ld_data);
        F_DOM:   nx.dom = 5'(ld_data);
        F_MON:   nx.mon = 4'(ld_data);
        F_YR:    nx.yr  = 7'(ld_data);
        default: nx = nx;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RTC_RESET;
    end else if (upd_en) begin
      cur_q <= nx;
    end
  end

  assign live_t = cur_q;

endmodule

// File: rtl/cal_rtc_regport.sv
module cal_rtc_regport
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  rtc_time_t         live_t,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_field,
  output logic [DATA_W-1:0] ld_data,
  output logic              arm_q,
  output logic              snap_req,
  output rtc_time_t         hold_t
);

  rtc_field_e        field;
  logic              rd_req, rd_start, wr_req;
  logic              rd_pend_q, rd_pend_d;
  logic              arm_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  rtc_time_t         hold_q, hold_d;
  rtc_time_t         rd_src;

  assign field    = rtc_field_e'(bus_addr);
  assign rd_req   = bus_sel && !bus_wr;
  assign wr_req   = bus_sel && bus_wr;
  assign rd_start = rd_req && !rd_pend_q;
  assign snap_req = rd_start && (field == F_SEC);

  assign ld_en    = wr_req && arm_q && (field != F_WREN) && field_ok(field, bus_wdata);
  assign ld_field = bus_addr;
  assign ld_data  = bus_wdata;

  always_comb begin
    rd_pend_d = rd_start;
    arm_d     = wr_req ? (field == F_WREN) : arm_q;
    hold_d    = snap_req ? live_t : hold_q;
    rd_src    = (field == F_SEC) ? live_t : hold_q;
    rdata_d   = rd_start ? field_value(rd_src, field) : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      arm_q     <= 1'b0;
      rdata_q   <= '0;
      hold_q    <= RTC_RESET;
    end else begin
      rd_pend_q <= rd_pend_d;
      if (wr_req) begin
        arm_q <= arm_d;
      end
      if (rd_start) begin
        rdata_q <= rdata_d;
      end
      if (snap_req) begin
        hold_q <= hold_d;
      end
    end
  end

  assign bus_wait  = rd_start;
  assign bus_rdata = rdata_q;
  assign hold_t    = hold_q;

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              sec_irq
);

  logic              rst_meta_q, rst_n_s;
  logic              sec_stb;
  logic              ld_en;
  logic [ADDR_W-1:0] ld_field;
  logic [DATA_W-1:0] ld_data;
  logic              arm_q;
  logic              snap_req;
  rtc_time_t         live_t;
  rtc_time_t         hold_t;

  // Reset asserts at once and leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  cal_rtc_prescaler #(.TICKS(TICKS_PER_SEC)) presc_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_en (tick_en),
    .sec_stb (sec_stb),
    .sec_irq (sec_irq)
  );

  cal_rtc_chain chain_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sec_stb  (sec_stb),
    .ld_en    (ld_en),
    .ld_field (ld_field),
    .ld_data  (ld_data),
    .live_t   (live_t)
  );

  cal_rtc_regport regs_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .live_t    (live_t),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .ld_en     (ld_en),
    .ld_field  (ld_field),
    .ld_data   (ld_data),
    .arm_q     (arm_q),
    .snap_req  (snap_req),
    .hold_t    (hold_t)
  );

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
#(
  parameter int TICKS = 32768
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wait,
  input logic              sec_irq,
  input logic              sec_stb,
  input logic              ld_en,
  input logic              arm_q,
  input logic              snap_req,
  input rtc_time_t         live_t,
  input rtc_time_t         hold_t
);

  localparam bit MULTI_TICK = (TICKS > 1);

  AST_ONE_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_wait) |=> !bus_wait); // R8

  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |-> !bus_wait); // R8

  AST_IRQ_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_stb |=> sec_irq); // R2

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (MULTI_TICK && sec_irq) |=> !sec_irq); // R2

  AST_SNAPSHOT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (hold_t == $past(live_t))); // R7

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(hold_t)); // R7

  AST_UNARMED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !arm_q && !sec_stb) |=> $stable(live_t)); // R9

  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr != 3'd7)) |=> !arm_q); // R9

  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_t.sec < 6'd60) && (live_t.mn < 6'd60) && (live_t.hr < 5'd24) &&
    (live_t.dow >= 3'd1) && (live_t.dom >= 5'd1) &&
    (live_t.mon >= 4'd1) && (live_t.mon <= 4'd12) && (live_t.yr < 7'd100)); // R11

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && !ld_en && live_t.sec == 6'd59 && live_t.mn == 6'd59 &&
     live_t.hr == 5'd23 && live_t.dow == 3'd7) |=> (live_t.dow == 3'd1)); // R4

endmodule

bind cal_rtc cal_rtc_chk #(.TICKS(TICKS_PER_SEC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wait (bus_wait),
  .sec_irq  (sec_irq),
  .sec_stb  (sec_stb),
  .ld_en    (ld_en),
  .arm_q    (arm_q),
  .snap_req (snap_req),
  .live_t   (live_t),
  .hold_t   (hold_t)
);

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb_top;

  localparam int TPS = 4;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       bus_sel;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_wait;
  logic       sec_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 0;

  cal_rtc #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .sec_irq   (sec_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && sec_irq) irq_cnt++;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int addr, input int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = 8'(data);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(input int addr, output int data, output int waits);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(addr);
    waits = 0;
    #1;
    while (bus_wait) begin
      waits++;
      @(negedge clk);
      #1;
    end
    data = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic set_field(input int addr, input int data);
    do_write(7, 8'hA5);
    do_write(addr, data);
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int w,
                          input int d, input int mo, input int y);
    set_field(6, y); set_field(5, mo); set_field(4, d); set_field(3, w);
    set_field(2, h); set_field(1, mi); set_field(0, s);
  endtask

  // Seconds read first (snapshot), then the held fields
  task automatic check_time(input string req, input int s, input int mi, input int h,
                            input int w, input int d, input int mo, input int y);
    int v, wt;
    int exp[7];
    exp = '{s, mi, h, w, d, mo, y};
    for (int a = 0; a < 7; a++) begin
      do_read(a, v, wt);
      check(req, $sformatf("field %0d", a), v, exp[a]);
      check("R8", $sformatf("wait states on field %0d", a), wt, 1);
    end
  endtask

  task automatic t_reset;
    int v, wt;
    check_time("R1", 0, 0, 0, 1, 1, 1, 0);
    do_read(7, v, wt);
    check("R7", "enable address reads zero", v, 0);
  endtask

  task automatic t_write_guard;
    do_write(1, 5);
    check_time("R9", 0, 0, 0, 1, 1, 1, 0);
    set_field(1, 5);
    do_write(1, 9);
    check_time("R9", 0, 5, 0, 1, 1, 1, 0);
    begin
      int v, wt;
      do_write(7, 0);
      do_read(3, v, wt);
      do_write(1, 12);
    end
    check_time("R9", 0, 12, 0, 1, 1, 1, 0);
    set_field(0, 3);
    do_write(1, 20);
    check_time("R9", 3, 12, 0, 1, 1, 1, 0);
    set_field(0, 60);
    set_field(3, 0);
    set_field(5, 13);
    set_field(6, 100);
    check_time("R11", 3, 12, 0, 1, 1, 1, 0);
  endtask

  task automatic t_step_irq;
    int base;
    base = irq_cnt;
    tick_n(TPS - 1);
    @(negedge clk);
    check("R2", "no irq before last tick", irq_cnt - base, 0);
    check_time("R2", 3, 12, 0, 1, 1, 1, 0);
    tick_n(1);
    @(negedge clk);
    check("R2", "irq cycles per second", irq_cnt - base, 1);
    check_time("R2", 4, 12, 0, 1, 1, 1, 0);
  endtask

  task automatic t_snapshot;
    int v, wt;
    set_field(0, 59);
    do_read(0, v, wt);
    check("R7", "live seconds", v, 59);
    tick_n(TPS);
    do_read(1, v, wt);
    check("R7", "stale minutes without seconds read", v, 12);
    do_read(0, v, wt);
    check("R7", "seconds after step", v, 0);
    do_read(1, v, wt);
    check("R7", "minutes after new snapshot", v, 13);
  endtask

  task automatic roll(input string req, input int h, input int w, input int d,
                      input int mo, input int y, input int eh, input int ew,
                      input int ed, input int emo, input int ey);
    set_time(59, 59, h, w, d, mo, y);
    tick_n(TPS);
    check_time(req, 0, 0, eh, ew, ed, emo, ey);
  endtask

  task automatic t_rollover;
    roll("R3", 10, 2, 5, 6, 30, 11, 2, 5, 6, 30);
    roll("R4", 23, 7, 28, 2, 23, 0, 1, 1, 3, 23);
    roll("R6", 23, 3, 28, 2, 24, 0, 4, 29, 2, 24);
    roll("R6", 23, 4, 29, 2, 24, 0, 5, 1, 3, 24);
    roll("R5", 23, 5, 31, 12, 99, 0, 6, 1, 1, 0);
    roll("R5", 23, 1, 30, 4, 10, 0, 2, 1, 5, 10);
    roll("R5", 23, 6, 31, 1, 10, 0, 7, 1, 2, 10);
    roll("R5", 23, 2, 30, 5, 10, 0, 3, 31, 5, 10);
  endtask

  task automatic t_collide;
    int v, wt;
    set_time(20, 10, 5, 2, 9, 7, 40);
    tick_n(TPS - 1);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
    #1;
    check("R10", "wait on colliding read", int'(bus_wait), 1);
    @(negedge clk);
    tick_en = 1'b0;
    #1;
    check("R10", "wait released", int'(bus_wait), 0);
    check("R10", "colliding seconds read", int'(bus_rdata), 20);
    bus_sel = 1'b0;
    do_read(0, v, wt);
    check("R10", "seconds after colliding step", v, 21);

    set_time(59, 10, 5, 2, 9, 7, 40);
    do_write(7, 0);
    tick_n(TPS - 1);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'd30;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    check_time("R10", 0, 30, 5, 2, 9, 7, 40);
  endtask

  task automatic finish_sim;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual hung, expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_guard();
    t_step_irq();
    t_snapshot();
    t_rollover();
    t_collide();
    repeat (2) @(negedge clk);
    finish_sim();
  end

endmodule